// File: doc/BRIEF.md
# Single-Channel DMA Engine with Indirect Source Fetch

This block is one DMA channel that copies data from memory to a peripheral register. It performs one transfer each time the peripheral raises its request, and it uses the bus in cycle-steal fashion. A transfer is a read at a source address followed by a write at a destination address. Between transfers the bus request is dropped, so other masters can use the bus.

When indirect fetch is selected, the word found at the source address is not the payload. It is a 32-bit pointer. The channel first reads that pointer as a longword, then reads the payload at the pointer with the programmed unit size, and finally writes the payload to the destination. In this mode the source address always moves by four bytes, because the pointer read is always four bytes. The direction of that move still follows the source address mode.

Software sets up the channel through a small register write port with four slots: source, destination, count and control. Bus read data is right-justified. A byte or word payload sits in the low bits of the data bus. A byte or word write drives the upper lanes as zero.

Top module: `dma_indirect_chan`

## Requirements
- R1: After reset, bus_req, dack and done are all low.
- R2: A transfer starts only when dreq is high, control bit 0 (channel enable) is 1, master_en is 1 and the count is nonzero. bus_req goes low for at least one cycle between transfers.
- R3: With control bit 7 (indirect) set, each transfer makes three accesses in this order. First, a read at the source address with bus_size 2 (longword). Second, a read at the fetched pointer with the programmed size. Third, a write of that data at the destination address.
- R4: In indirect mode the source address changes by 4 after each transfer, following the source mode. Control bits 4:3 give the source mode: 0 fixed, 1 increment, 2 decrement. The unit size has no effect on this step.
- R5: In normal mode each transfer makes two accesses: a read at the source address, then a write at the destination address, both with the programmed size. Control bits 2:1 give the size: 0 byte, 1 word, 2 longword. The source address steps by 1, 2 or 4 according to its mode.
- R6: The destination address steps by the unit size according to its own mode in control bits 6:5, using the same encoding as the source mode.
- R7: The count drops by one per completed transfer. When it reaches zero, done goes high and further requests start no access. Writing the count slot (cfg_sel 2) or the control slot (cfg_sel 3) clears done. cfg_sel 0 writes the source address and cfg_sel 1 writes the destination address.
- R8: dack is a one-cycle pulse. It is high in the cycle after the destination write is accepted.
- R9: While bus_req is high and bus_ready is low, the address, direction and size hold steady.
- R10: If channel enable or master_en is cleared during a transfer, the current access completes and the transfer is abandoned. The count and addresses are left unchanged. A later request repeats the whole transfer.
- R11: The data read uses the fetched pointer exactly as read, with no alignment correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Slot select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write data |
| master_en | input | 1 | Global DMA enable |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Peripheral acknowledge pulse |
| done | output | 1 | Count exhausted |
| bus_req | output | 1 | Bus access request |
| bus_write | output | 1 | 1 for a write access |
| bus_size | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_ready | input | 1 | Access accepted this cycle |

## Verification
The bench builds the block with AW of 32 and CW of 8. With these values, ten-transfer runs and the exhaustion of the count fit in short directed scenarios, while full 32-bit pointers and addresses can still be checked. The bench's bus responder adds a wait state that can be set per scenario. A long wait holds an access open while the master enable is withdrawn, which exercises the halt path. The scenarios also cover an unaligned pointer and all three address modes.

// File: rtl/dmaic_pkg.sv
package dmaic_pkg;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} size_e;
  typedef enum logic [1:0] {AM_FIXED = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2} amode_e;
  typedef enum logic [1:0] {PH_IDLE, PH_PTR, PH_RD, PH_WR} phase_e;

  typedef struct packed {
    logic       indirect;
    logic [1:0] dmode;
    logic [1:0] smode;
    logic [1:0] size;
    logic       en;
  } ctrl_t;

  localparam int unsigned PTR_BYTES = 4;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: unit_bytes = 3'd1;
      SZ_WORD: unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_WORD: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dmaic_step.sv
module dmaic_step
  import dmaic_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  input  logic [2:0]    bytes,
  output logic [AW-1:0] next
);

  always_comb begin
    case (mode)
      AM_INC:  next = addr + AW'(bytes);
      AM_DEC:  next = addr - AW'(bytes);
      default: next = addr;
    endcase
  end

endmodule

// File: rtl/dmaic_regfile.sv
module dmaic_regfile
  import dmaic_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          xfer_done,
  input  logic [AW-1:0] src_next,
  input  logic [AW-1:0] dst_next,
  output logic [AW-1:0] sar,
  output logic [AW-1:0] dar,
  output logic [CW-1:0] count,
  output ctrl_t         ctrl,
  output logic          count_nz,
  output logic          done
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic cfg_unused;
  assign cfg_unused = ^cfg_wdata;

  assign count_nz = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sar   <= '0;
      dar   <= '0;
      count <= '0;
      ctrl  <= '0;
      done  <= 1'b0;
    end else begin
      if (xfer_done) begin
        sar   <= src_next;
        dar   <= dst_next;
        count <= count - CNT_ONE;
        if (count == CNT_ONE) done <= 1'b1;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: sar <= cfg_wdata[AW-1:0];
          2'd1: dar <= cfg_wdata[AW-1:0];
          2'd2: begin count <= cfg_wdata[CW-1:0]; done <= 1'b0; end
          default: begin ctrl <= ctrl_t'(cfg_wdata[7:0]); done <= 1'b0; end
        endcase
      end
    end
  end

  // R7
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !cfg_we |=> count == $past(count) - CNT_ONE);

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(xfer_done));

endmodule

// File: rtl/dmaic_seq.sv
module dmaic_seq
  import dmaic_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dreq,
  input  logic          active,
  input  logic          count_nz,
  input  logic          indirect,
  input  logic [1:0]    size,
  input  logic [AW-1:0] sar,
  input  logic [AW-1:0] dar,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ready,
  output logic          bus_req,
  output logic          bus_write,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  output logic          xfer_done,
  output logic          dack
);

  phase_e      phase;
  logic        ind_q;
  logic [31:0] ptr_q;
  logic [31:0] data_q;
  logic        start_ok;
  logic        access_end;

  assign start_ok   = dreq && active && count_nz;
  assign access_end = (phase != PH_IDLE) && bus_ready;
  assign xfer_done  = (phase == PH_WR) && bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      ind_q  <= 1'b0;
      ptr_q  <= '0;
      data_q <= '0;
      dack   <= 1'b0;
    end else begin
      dack <= xfer_done;
      case (phase)
        PH_IDLE: if (start_ok) begin
          ind_q <= indirect;
          phase <= indirect ? PH_PTR : PH_RD;
        end
        PH_PTR: if (bus_ready) begin
          ptr_q <= bus_rdata;
          phase <= active ? PH_RD : PH_IDLE;
        end
        PH_RD: if (bus_ready) begin
          data_q <= bus_rdata;
          phase  <= active ? PH_WR : PH_IDLE;
        end
        default: if (bus_ready) phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req   = (phase != PH_IDLE);
    bus_write = (phase == PH_WR);
    bus_size  = (phase == PH_PTR) ? SZ_LONG : size;
    bus_wdata = data_q & lane_mask(size);
    case (phase)
      PH_PTR:  bus_addr = sar;
      PH_RD:   bus_addr = ind_q ? ptr_q[AW-1:0] : sar;
      default: bus_addr = dar;
    endcase
  end

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_write));

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> !dack);

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(start_ok));

  // R10
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_end && !active && !bus_write |=> !bus_req);

endmodule

// File: rtl/dma_indirect_chan.sv
module dma_indirect_chan
  import dmaic_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          master_en,
  input  logic          dreq,
  output logic          dack,
  output logic          done,
  output logic          bus_req,
  output logic          bus_write,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ready
);

  localparam logic [2:0] PTR_STEP = 3'(PTR_BYTES);

  logic [AW-1:0] sar, dar, src_next, dst_next;
  logic [CW-1:0] count;
  ctrl_t         ctrl;
  logic          count_nz;
  logic          chan_active;
  logic          xfer_done;
  logic [2:0]    data_bytes, src_bytes;

  assign chan_active = ctrl.en && master_en;
  assign data_bytes  = unit_bytes(ctrl.size);
  assign src_bytes   = ctrl.indirect ? PTR_STEP : data_bytes;

  dmaic_step #(.AW(AW)) u_src_step (
    .addr(sar), .mode(ctrl.smode), .bytes(src_bytes), .next(src_next));

  dmaic_step #(.AW(AW)) u_dst_step (
    .addr(dar), .mode(ctrl.dmode), .bytes(data_bytes), .next(dst_next));

  dmaic_regfile #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_done(xfer_done), .src_next(src_next),
    .dst_next(dst_next), .sar(sar), .dar(dar), .count(count), .ctrl(ctrl),
    .count_nz(count_nz), .done(done));

  dmaic_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .active(chan_active),
    .count_nz(count_nz), .indirect(ctrl.indirect), .size(ctrl.size),
    .sar(sar), .dar(dar), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .bus_req(bus_req), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .xfer_done(xfer_done),
    .dack(dack));

  // R4
  ind_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !cfg_we && ctrl.indirect && ctrl.smode == AM_INC
    |=> sar == $past(sar) + AW'(PTR_BYTES));

endmodule

// File: tb/dma_indirect_chan_test.sv
module dma_indirect_chan_test;

  localparam int AW = 32;
  localparam int CW = 8;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic master_en = 1'b0;
  logic dreq = 1'b0;
  logic dack, done, bus_req, bus_write;
  logic [1:0] bus_size;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ready = 1'b0;

  always #2 clk = ~clk;

  dma_indirect_chan #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .master_en(master_en), .dreq(dreq), .dack(dack),
    .done(done), .bus_req(bus_req), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready));

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int lat = 0;
  int wcnt = 0;
  int ack_cnt = 0;
  int ack_cyc = 0;
  int wr_cyc = 0;
  int ack_wide = 0;
  logic ack_prev = 1'b0;
  logic [7:0] mem [logic [31:0]];
  logic [31:0] log_addr [$];
  logic [1:0]  log_size [$];
  logic        log_wr [$];

  function automatic logic [31:0] rd_mem(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++)
      if (mem.exists(a + 32'(k))) v[8*k +: 8] = mem[a + 32'(k)];
    return v;
  endfunction

  task automatic wr_mem(input logic [31:0] a, input logic [31:0] v, input int n);
    for (int k = 0; k < n; k++) mem[a + 32'(k)] = v[8*k +: 8];
  endtask

  // bus responder, ack monitor and watchdog, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (dack) begin
      ack_cnt++;
      ack_cyc = cyc;
      if (ack_prev) ack_wide++;
    end
    ack_prev = dack;
    if (!rst_n) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_ready) begin
      bus_ready = 1'b0;
    end else if (bus_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        log_addr.push_back(bus_addr);
        log_size.push_back(bus_size);
        log_wr.push_back(bus_write);
        if (bus_write) begin
          wr_mem(bus_addr, bus_wdata, (bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4);
          wr_cyc = cyc;
        end else bus_rdata = rd_mem(bus_addr, bus_size);
        bus_ready = 1'b1;
      end
    end
    if (cyc == WD_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, cycle %0d expected below %0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic clear_log();
    log_addr.delete(); log_size.delete(); log_wr.delete();
  endtask

  task automatic do_xfer(input string req);
    int start = ack_cnt;
    int k = 0;
    dreq = 1'b1;
    while (ack_cnt == start && k < 300) begin tick(1); k++; end
    dreq = 1'b0;
    check(ack_cnt == start + 1, req, 32'(ack_cnt - start), 32'd1);
    // R8: ack one cycle after the write was accepted, low one cycle later
    check(ack_cyc == wr_cyc + 1, "R8 ack timing", 32'(ack_cyc), 32'(wr_cyc + 1));
    tick(1);
    check(dack == 1'b0, "R8 ack width", 32'(dack), 32'd0);
  endtask

  task automatic check_acc(input int i, input logic [31:0] a, input logic [1:0] sz,
                           input logic wr, input string req);
    if (i < log_addr.size()) begin
      check(log_addr[i] == a, req, log_addr[i], a);
      check(log_size[i] == sz, req, 32'(log_size[i]), 32'(sz));
      check(log_wr[i] == wr, req, 32'(log_wr[i]), 32'(wr));
    end else check(1'b0, req, 32'(log_addr.size()), 32'(i + 1));
  endtask

  task automatic t_reset();
    check(bus_req == 1'b0, "R1 bus_req", 32'(bus_req), 32'd0);
    check(dack == 1'b0, "R1 dack", 32'(dack), 32'd0);
    check(done == 1'b0, "R1 done", 32'(done), 32'd0);
  endtask

  // indirect, byte, source increment, destination fixed, ten transfers
  task automatic t_indirect_byte();
    logic [31:0] ptr;
    for (int i = 0; i < 10; i++) begin
      wr_mem(32'h0040_0000 + 32'(4*i), 32'h0045_0000 + 32'(16*i), 4);
      wr_mem(32'h0045_0000 + 32'(16*i), 32'h55 + 32'(i), 1);
    end
    cfg(2'd0, 32'h0040_0000);
    cfg(2'd1, 32'h0400_0156);
    cfg(2'd2, 32'd10);
    cfg(2'd3, 32'h89);
    master_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      clear_log();
      do_xfer("R3 indirect ack");
      check(log_addr.size() == 3, "R3 access count", 32'(log_addr.size()), 32'd3);
      ptr = 32'h0045_0000 + 32'(16*i);
      // R4: pointer address moves by 4 with byte size
      check_acc(0, 32'h0040_0000 + 32'(4*i), 2'd2, 1'b0, "R4 R3 pointer read");
      check_acc(1, ptr, 2'd0, 1'b0, "R3 data read");
      // R6: fixed destination
      check_acc(2, 32'h0400_0156, 2'd0, 1'b1, "R6 R3 dest write");
      check(rd_mem(32'h0400_0156, 2'd0) == 32'h55 + 32'(i), "R3 data",
            rd_mem(32'h0400_0156, 2'd0), 32'h55 + 32'(i));
      check(done == (i == 9), "R7 done", 32'(done), 32'(i == 9));
    end
    // R7: request after exhaustion is ignored
    clear_log();
    dreq = 1'b1;
    tick(20);
    dreq = 1'b0;
    check(log_addr.size() == 0, "R7 no access after zero", 32'(log_addr.size()), 32'd0);
    check(done == 1'b1, "R7 done held", 32'(done), 32'd1);
  endtask

  // normal mode, word, both increment
  task automatic t_normal_word();
    wr_mem(32'h1000, 32'hA1B2, 2);
    wr_mem(32'h1002, 32'hC3D4, 2);
    wr_mem(32'h1004, 32'hE5F6, 2);
    cfg(2'd0, 32'h1000);
    cfg(2'd1, 32'h2000);
    cfg(2'd2, 32'd3);
    check(done == 1'b0, "R7 done cleared by count write", 32'(done), 32'd0);
    cfg(2'd3, 32'h2B);
    for (int i = 0; i < 3; i++) begin
      clear_log();
      do_xfer("R5 normal ack");
      check(log_addr.size() == 2, "R5 access count", 32'(log_addr.size()), 32'd2);
      check_acc(0, 32'h1000 + 32'(2*i), 2'd1, 1'b0, "R5 source read");
      check_acc(1, 32'h2000 + 32'(2*i), 2'd1, 1'b1, "R6 dest write inc");
      check(rd_mem(32'h2000 + 32'(2*i), 2'd1) == rd_mem(32'h1000 + 32'(2*i), 2'd1),
            "R5 word data", rd_mem(32'h2000 + 32'(2*i), 2'd1), rd_mem(32'h1000 + 32'(2*i), 2'd1));
    end
    check(done == 1'b1, "R7 done after 3", 32'(done), 32'd1);
  endtask

  // normal mode, longword, source decrement, with wait states
  task automatic t_normal_long_dec();
    lat = 2;
    wr_mem(32'h3008, 32'hDEAD_BEEF, 4);
    wr_mem(32'h3004, 32'h1234_5678, 4);
    cfg(2'd0, 32'h3008);
    cfg(2'd1, 32'h5000);
    cfg(2'd2, 32'd2);
    cfg(2'd3, 32'h15);
    for (int i = 0; i < 2; i++) begin
      clear_log();
      do_xfer("R5 long ack");
      check_acc(0, 32'h3008 - 32'(4*i), 2'd2, 1'b0, "R5 decrement read");
      check_acc(1, 32'h5000, 2'd2, 1'b1, "R6 fixed dest");
      check(rd_mem(32'h5000, 2'd2) == rd_mem(32'h3008 - 32'(4*i), 2'd2), "R5 long data",
            rd_mem(32'h5000, 2'd2), rd_mem(32'h3008 - 32'(4*i), 2'd2));
    end
    lat = 0;
  endtask

  // indirect, word, source fixed, destination decrement, unaligned pointer
  task automatic t_indirect_fixed();
    wr_mem(32'h6000, 32'h0000_7003, 4);
    wr_mem(32'h7003, 32'h9ABC, 2);
    cfg(2'd0, 32'h6000);
    cfg(2'd1, 32'h8000);
    cfg(2'd2, 32'd2);
    cfg(2'd3, 32'hC3);
    for (int i = 0; i < 2; i++) begin
      clear_log();
      do_xfer("R3 indirect word ack");
      check_acc(0, 32'h6000, 2'd2, 1'b0, "R4 fixed pointer address");
      check_acc(1, 32'h7003, 2'd1, 1'b0, "R11 unaligned pointer used as is");
      check_acc(2, 32'h8000 - 32'(2*i), 2'd1, 1'b1, "R6 dest decrement");
      check(rd_mem(32'h8000 - 32'(2*i), 2'd1) == 32'h9ABC, "R3 word data",
            rd_mem(32'h8000 - 32'(2*i), 2'd1), 32'h9ABC);
    end
  endtask

  // enables: channel disabled, then master enable withdrawn mid transfer
  task automatic t_halt();
    int k = 0;
    wr_mem(32'h9000, 32'h0000_9100, 4);
    wr_mem(32'h9100, 32'h77, 1);
    wr_mem(32'h9200, 32'h00, 1);
    cfg(2'd0, 32'h9000);
    cfg(2'd1, 32'h9200);
    cfg(2'd2, 32'd1);
    cfg(2'd3, 32'h88);
    clear_log();
    dreq = 1'b1;
    tick(10);
    check(bus_req == 1'b0 && log_addr.size() == 0, "R2 channel disabled",
          32'(log_addr.size()), 32'd0);
    lat = 6;
    cfg(2'd3, 32'h89);
    while (!bus_req && k < 50) begin tick(1); k++; end
    master_en = 1'b0;
    tick(20);
    check(log_addr.size() == 1, "R10 only pointer read", 32'(log_addr.size()), 32'd1);
    check(bus_req == 1'b0, "R10 bus released", 32'(bus_req), 32'd0);
    check(done == 1'b0, "R10 count kept", 32'(done), 32'd0);
    check(rd_mem(32'h9200, 2'd0) == 32'h0, "R10 no write", rd_mem(32'h9200, 2'd0), 32'h0);
    master_en = 1'b1;
    do_xfer("R10 resumed ack");
    check(log_addr.size() == 4, "R10 whole transfer repeated", 32'(log_addr.size()), 32'd4);
    check_acc(1, 32'h9000, 2'd2, 1'b0, "R10 same pointer address");
    check(rd_mem(32'h9200, 2'd0) == 32'h77, "R10 data", rd_mem(32'h9200, 2'd0), 32'h77);
    check(done == 1'b1, "R7 done after resume", 32'(done), 32'd1);
    lat = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_indirect_byte();
    t_normal_word();
    t_normal_long_dec();
    t_indirect_fixed();
    t_halt();
    check(ack_wide == 0, "R8 ack never wider than one cycle", 32'(ack_wide), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule